// File: doc/BRIEF.md
# Debug System Bus Access Master

This block gives an external debugger direct reads and writes of system memory with no hart involved. The debugger drives a small register port. Through it, the debugger loads a 64-bit address as two 32-bit halves and loads a 64-bit data value as two 32-bit halves. It also sets the access size and an optional address auto-increment in a control/status word. Writing the low data half starts a bus write. Setting a trigger bit in the control word starts a bus read, and the read result lands in the data registers.

On the memory side the block is a single-beat master. A request channel carries address, write data, size and direction under a valid/ready handshake. Once `m_req_valid` is high, it stays high and every request field holds still until the cycle in which `m_req_ready` is sampled high. The memory may hold `m_req_ready` low for as long as it needs. A response is a one-cycle `m_rsp_valid` pulse with an error flag and read data. The block accepts it in any cycle after the request has been taken, and it never back-pressures a response.

Errors stay visible until the debugger clears them. There is a sticky busy-error flag for register traffic that arrives during an access. There is also a 3-bit error code for bad sizes, misalignment and error responses. While either one is set, no new access starts.

Top module: `sba_master`

## Requirements
- R1: After reset the control word reads busy 0, busy-error 0, error code 0, auto-increment 0 and size 3 (64-bit), and the address and data registers read 0.
- R2: Register selects are 0 control, 1 address low, 2 address high, 3 data low and 4 data high. The control word reads the address width (64 by default) in bits 17:10, 32-bit support in bit 18 and 64-bit support in bit 19.
- R3: The address low and address high halves are written separately, and each reads back the value written.
- R4: Writing data low starts a bus write with the current size. Writing data high starts nothing. A 64-bit write carries {data high, data low}, and a 32-bit write carries data low in bits 31:0.
- R5: Writing the control word with bit 9 set starts a bus read. A 64-bit read fills both data halves. A 32-bit read takes bits 31:0 of the response into data low and leaves data high unchanged.
- R6: Control bit 0 (busy) is high from the cycle after a start until the response arrives. The request holds valid, address, data, size and direction stable until it is accepted.
- R7: With auto-increment (control bit 5) set, the address grows by 4 or 8 bytes after each access that completes without error. After an error response the address stays where it was.
- R8: Any read or write of selects 1 to 4 while busy sets busy-error (control bit 1), and that access is dropped.
- R9: While busy-error is set or the error code is nonzero, no access starts. Writing 1 to bit 1 clears busy-error, and writing 1s to bits 4:2 clears the matching error-code bits.
- R10: Size (control bits 8:6) accepts only code 2 (32-bit) and code 3 (64-bit). Any other code gives error 4 and no bus request.
- R11: A 64-bit access with address bits 2:0 nonzero, or a 32-bit access with address bits 1:0 nonzero, gives error 3 and no bus request.
- R12: An error response sets the error code to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read data is combinational from reg_sel) |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| m_req_valid | output | 1 | Bus request valid |
| m_req_ready | input | 1 | Bus request ready |
| m_req_we | output | 1 | Bus request is a write |
| m_req_addr | output | ADDR_W | Bus request byte address |
| m_req_size | output | 3 | Access size code (2 or 3) |
| m_req_wdata | output | 64 | Bus write data |
| m_rsp_valid | input | 1 | Bus response valid (one-cycle pulse) |
| m_rsp_err | input | 1 | Bus response error |
| m_rsp_rdata | input | 64 | Bus read data |

## Verification
The bench sweeps all eight size codes against all eight low-address offsets and counts bus transactions. A design that checks alignment with the wrong mask, or that issues a request for an illegal size, leaves a wrong error code or an extra transaction.

Auto-increment is run at both sizes, and then against an error response. A design that steps by the wrong amount, or that steps after a failed access, leaves a wrong final address.

The memory model stalls on purpose while the bench fires register traffic at the block. A design that lets those writes through corrupts the value stored in memory. A design that starts an access while an error flag is set shows an extra transaction. Narrow reads are checked so that a design which overwrites the high data half gets caught.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_ADDR_LO = 3'd1,
    SEL_ADDR_HI = 3'd2,
    SEL_DATA_LO = 3'd3,
    SEL_DATA_HI = 3'd4
  } reg_sel_e;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_BUS   = 3'd2,
    ERR_ALIGN = 3'd3,
    ERR_SIZE  = 3'd4
  } sba_err_e;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} port_state_e;

  localparam logic [2:0] SZ_32 = 3'd2;
  localparam logic [2:0] SZ_64 = 3'd3;

  // control word bit positions
  localparam int unsigned B_BUSY    = 0;
  localparam int unsigned B_BUSYERR = 1;
  localparam int unsigned B_ERR     = 2;   // 3 bits
  localparam int unsigned B_AUTOINC = 5;
  localparam int unsigned B_SIZE    = 6;   // 3 bits
  localparam int unsigned B_READGO  = 9;
  localparam int unsigned B_AWIDTH  = 10;  // 8 bits
  localparam int unsigned B_CAP32   = 18;
  localparam int unsigned B_CAP64   = 19;
endpackage

// File: rtl/sba_check.sv
module sba_check
  import sba_pkg::*;
#(
  parameter bit HAS_32 = 1'b1,
  parameter bit HAS_64 = 1'b1
) (
  input  logic [2:0] size,
  input  logic [2:0] addr_low,
  output sba_err_e   err,
  output logic [3:0] nbytes
);
  always_comb begin
    err    = ERR_NONE;
    nbytes = 4'd0;
    if (HAS_64 && size == SZ_64) begin
      nbytes = 4'd8;
      if (addr_low != 3'd0) err = ERR_ALIGN;
    end else if (HAS_32 && size == SZ_32) begin
      nbytes = 4'd4;
      if (addr_low[1:0] != 2'd0) err = ERR_ALIGN;
    end else begin
      err = ERR_SIZE;
    end
  end
endmodule

// File: rtl/sba_port.sv
module sba_port
  import sba_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_we,
  input  logic [2:0] start_size,
  output logic       busy,
  output logic       done,
  output logic       done_err,
  output logic       req_valid,
  input  logic       req_ready,
  output logic       req_we,
  output logic [2:0] req_size,
  input  logic       rsp_valid,
  input  logic       rsp_err
);
  port_state_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      req_we   <= 1'b0;
      req_size <= 3'd0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q     <= ST_REQ;
          req_we   <= start_we;
          req_size <= start_size;
        end
        ST_REQ:  if (req_ready) st_q <= ST_RSP;
        ST_RSP:  if (rsp_valid) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (st_q == ST_REQ);
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_RSP) && rsp_valid;
  assign done_err  = done && rsp_err;

  // R6
  req_ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_we) && $stable(req_size));

  // R8
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/sba_master.sv
module sba_master
  import sba_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter bit          HAS_32 = 1'b1,
  parameter bit          HAS_64 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              m_req_valid,
  input  logic              m_req_ready,
  output logic              m_req_we,
  output logic [ADDR_W-1:0] m_req_addr,
  output logic [2:0]        m_req_size,
  output logic [63:0]       m_req_wdata,
  input  logic              m_rsp_valid,
  input  logic              m_rsp_err,
  input  logic [63:0]       m_rsp_rdata
);
  localparam int unsigned HI_W = ADDR_W - 32;

  logic [ADDR_W-1:0] addr_q;
  logic [63:0]       data_q;
  logic              busy_err_q;
  sba_err_e          bus_err_q;
  logic              autoinc_q;
  logic [2:0]        size_q;
  logic [3:0]        cur_bytes_q;

  logic     busy, done, done_err;
  logic     ctrl_wr, dreg_acc, collide, blocked;
  logic     go_wr, go_rd, go, start, bad_go;
  logic [2:0] eff_size;
  sba_err_e chk_err;
  logic [3:0] chk_bytes;

  assign ctrl_wr  = reg_wr && reg_sel == SEL_CTRL;
  assign dreg_acc = (reg_wr || reg_rd) &&
                    (reg_sel == SEL_ADDR_LO || reg_sel == SEL_ADDR_HI ||
                     reg_sel == SEL_DATA_LO || reg_sel == SEL_DATA_HI);
  assign collide  = dreg_acc && busy;
  assign blocked  = busy || busy_err_q || (bus_err_q != ERR_NONE);
  assign eff_size = ctrl_wr ? reg_wdata[B_SIZE +: 3] : size_q;
  assign go_wr    = reg_wr && reg_sel == SEL_DATA_LO && !blocked;
  assign go_rd    = ctrl_wr && reg_wdata[B_READGO] && !blocked;
  assign go       = go_wr || go_rd;
  assign start    = go && chk_err == ERR_NONE;
  assign bad_go   = go && chk_err != ERR_NONE;

  sba_check #(.HAS_32(HAS_32), .HAS_64(HAS_64)) check_i (
    .size(eff_size), .addr_low(addr_q[2:0]), .err(chk_err), .nbytes(chk_bytes)
  );

  sba_port port_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_we(go_wr), .start_size(eff_size),
    .busy(busy), .done(done), .done_err(done_err),
    .req_valid(m_req_valid), .req_ready(m_req_ready), .req_we(m_req_we),
    .req_size(m_req_size), .rsp_valid(m_rsp_valid), .rsp_err(m_rsp_err)
  );

  assign m_req_addr  = addr_q;
  assign m_req_wdata = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q      <= '0;
      data_q      <= '0;
      busy_err_q  <= 1'b0;
      bus_err_q   <= ERR_NONE;
      autoinc_q   <= 1'b0;
      size_q      <= SZ_64;
      cur_bytes_q <= 4'd0;
    end else begin
      if (ctrl_wr) begin
        autoinc_q <= reg_wdata[B_AUTOINC];
        size_q    <= reg_wdata[B_SIZE +: 3];
      end
      if (collide) busy_err_q <= 1'b1;
      else if (ctrl_wr && reg_wdata[B_BUSYERR]) busy_err_q <= 1'b0;

      if (bad_go) bus_err_q <= chk_err;
      else if (done_err) bus_err_q <= ERR_BUS;
      else if (ctrl_wr) bus_err_q <= sba_err_e'(bus_err_q & ~reg_wdata[B_ERR +: 3]);

      if (start) cur_bytes_q <= chk_bytes;

      if (reg_wr && !busy) begin
        if (reg_sel == SEL_ADDR_LO) addr_q[31:0] <= reg_wdata;
        if (reg_sel == SEL_ADDR_HI) addr_q[ADDR_W-1:32] <= reg_wdata[HI_W-1:0];
        if (reg_sel == SEL_DATA_LO) data_q[31:0] <= reg_wdata;
        if (reg_sel == SEL_DATA_HI) data_q[63:32] <= reg_wdata;
      end

      if (done && !done_err) begin
        if (!m_req_we) begin
          if (cur_bytes_q == 4'd8) data_q <= m_rsp_rdata;
          else data_q[31:0] <= m_rsp_rdata[31:0];
        end
        if (autoinc_q) addr_q <= addr_q + ADDR_W'(cur_bytes_q);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[B_BUSY]         = busy;
        reg_rdata[B_BUSYERR]      = busy_err_q;
        reg_rdata[B_ERR +: 3]     = bus_err_q;
        reg_rdata[B_AUTOINC]      = autoinc_q;
        reg_rdata[B_SIZE +: 3]    = size_q;
        reg_rdata[B_AWIDTH +: 8]  = 8'(ADDR_W);
        reg_rdata[B_CAP32]        = HAS_32;
        reg_rdata[B_CAP64]        = HAS_64;
      end
      SEL_ADDR_LO: reg_rdata = addr_q[31:0];
      SEL_ADDR_HI: reg_rdata = 32'(addr_q[ADDR_W-1:32]);
      SEL_DATA_LO: reg_rdata = data_q[31:0];
      SEL_DATA_HI: reg_rdata = data_q[63:32];
      default:     reg_rdata = '0;
    endcase
  end

  // R9
  no_start_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req_valid) |-> $past(!busy_err_q && bus_err_q == ERR_NONE));

  // R6
  req_payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_valid && !m_req_ready |=> $stable(m_req_addr) && $stable(m_req_wdata));

  // R11
  req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_valid |-> ((m_req_size == SZ_64 && m_req_addr[2:0] == 3'd0) ||
                     (m_req_size == SZ_32 && m_req_addr[1:0] == 2'd0)));

  // R8
  busy_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_err_q) |-> $past(busy));

  // R12
  rsp_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |=> bus_err_q == ERR_BUS);

  // R7
  err_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |=> $stable(addr_q));
endmodule

// File: tb/sba_master_tb.sv
`timescale 1ns/1ps
module sba_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        m_req_valid, m_req_we;
  logic        m_req_ready = 1'b0;
  logic [63:0] m_req_addr, m_req_wdata;
  logic [2:0]  m_req_size;
  logic        m_rsp_valid = 1'b0, m_rsp_err = 1'b0;
  logic [63:0] m_rsp_rdata = '0;

  always #2.5 clk = ~clk;

  sba_master dut_i (.*);

  int n_chk = 0, n_err = 0;
  int txn_cnt = 0, stall_n = 0, wcnt = 0;
  int hold_viol = 0;
  bit finished = 0;
  logic [63:0] mem [16];
  logic        prev_stall = 0;
  logic [63:0] prev_addr, prev_wdata;

  // memory model: valid addresses 0x00..0x7F, index = addr[6:3]
  always @(posedge clk) begin
    if (!rst_n) begin
      m_req_ready <= 1'b0; m_rsp_valid <= 1'b0; wcnt <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      m_rsp_valid <= 1'b0;
      if (m_req_valid && m_req_ready) begin
        m_req_ready <= 1'b0; wcnt <= 0; txn_cnt <= txn_cnt + 1;
        m_rsp_valid <= 1'b1;
        m_rsp_err   <= (m_req_addr >= 64'h80);
        m_rsp_rdata <= '0;
        if (m_req_addr < 64'h80) begin
          if (m_req_we) begin
            if (m_req_size == 3'd3) mem[m_req_addr[6:3]] <= m_req_wdata;
            else if (m_req_addr[2]) mem[m_req_addr[6:3]][63:32] <= m_req_wdata[31:0];
            else mem[m_req_addr[6:3]][31:0] <= m_req_wdata[31:0];
          end else begin
            if (m_req_size == 3'd3) m_rsp_rdata <= mem[m_req_addr[6:3]];
            else if (m_req_addr[2]) m_rsp_rdata <= {32'h0, mem[m_req_addr[6:3]][63:32]};
            else m_rsp_rdata <= {32'h0, mem[m_req_addr[6:3]][31:0]};
          end
        end
      end else if (m_req_valid) begin
        if (wcnt >= stall_n) m_req_ready <= 1'b1;
        else wcnt <= wcnt + 1;
      end
      // R6 handshake stability monitor
      if (prev_stall && (!m_req_valid || m_req_addr != prev_addr || m_req_wdata != prev_wdata))
        hold_viol <= hold_viol + 1;
      prev_stall <= m_req_valid && !m_req_ready;
      prev_addr  <= m_req_addr;
      prev_wdata <= m_req_wdata;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_sel = sel;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(3'd0, v);
      if (!v[0]) break;
    end
  endtask

  localparam logic [31:0] CLR = 32'h1E;  // clear busy-error and all error bits

  initial begin
    logic [31:0] v;
    int t0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R2
    rd(3'd0, v);
    check("R1 ctrl low fields", v[9:0], 64'(3 << 6));
    check("R2 width and caps", v[31:10], 64'((1 << 9) | (1 << 8) | 64));
    rd(3'd1, v); check("R1 addr lo", v, 0);
    rd(3'd3, v); check("R1 data lo", v, 0);
    // R3
    wr(3'd2, 32'h1234_5678); wr(3'd1, 32'h9ABC_DEF0);
    rd(3'd2, v); check("R3 addr hi", v, 64'h1234_5678);
    rd(3'd1, v); check("R3 addr lo", v, 64'h9ABC_DEF0);
    wr(3'd2, 0);
    // R4: 64-bit write, data high alone starts nothing
    wr(3'd1, 32'h10);
    t0 = txn_cnt;
    wr(3'd4, 32'hA5A5_0001);
    repeat (4) @(negedge clk);
    check("R4 data hi no txn", 64'(txn_cnt - t0), 0);
    wr(3'd3, 32'h5A5A_0002); wait_idle();
    check("R4 64-bit write", mem[2], 64'hA5A5_0001_5A5A_0002);
    wr(3'd1, 32'h18); wr(3'd4, 32'h0BAD_0003); wr(3'd3, 32'h0BAD_0004); wait_idle();
    // R5: 64-bit read of 0x10
    wr(3'd1, 32'h10); wr(3'd0, (3 << 6) | (1 << 9)); wait_idle();
    rd(3'd4, v); check("R5 read hi", v, 64'hA5A5_0001);
    rd(3'd3, v); check("R5 read lo", v, 64'h5A5A_0002);
    // R10 / R11 sweep: every size code against every offset
    for (int sz = 0; sz < 8; sz++) begin
      for (int off = 0; off < 8; off++) begin
        logic [31:0] lo, hi;
        int exp_err;
        lo = 32'h1000 + 32'(sz * 16 + off);
        hi = 32'hC0DE_0000 + 32'(sz * 16 + off);
        wr(3'd1, 32'h40 + 32'(off));
        wr(3'd0, 32'(sz << 6) | CLR);
        wr(3'd4, hi);
        t0 = txn_cnt;
        wr(3'd3, lo);
        wait_idle();
        if (sz != 2 && sz != 3) exp_err = 4;
        else if (sz == 3 && off != 0) exp_err = 3;
        else if (sz == 2 && (off % 4) != 0) exp_err = 3;
        else exp_err = 0;
        rd(3'd0, v);
        check(exp_err == 4 ? "R10 size code" : "R11 alignment", v[4:2], 64'(exp_err));
        check(exp_err == 4 ? "R10 txn count" : "R11 txn count", 64'(txn_cnt - t0),
              exp_err == 0 ? 1 : 0);
        if (exp_err == 0) begin
          if (sz == 3) check("R4 64-bit sweep data", mem[8], {hi, lo});
          else if (off == 4) check("R4 32-bit upper lane", 64'(mem[8][63:32]), 64'(lo));
          else check("R4 32-bit lower lane", 64'(mem[8][31:0]), 64'(lo));
        end
      end
    end
    // R7: 64-bit auto-increment
    wr(3'd0, (1 << 5) | (3 << 6) | CLR);
    wr(3'd1, 0);
    for (int i = 0; i < 4; i++) begin
      wr(3'd4, 32'(i)); wr(3'd3, 32'h100 + 32'(i)); wait_idle();
    end
    rd(3'd1, v); check("R7 addr after 4x8", v, 64'h20);
    for (int i = 0; i < 4; i++)
      check("R7 autoinc 64 data", mem[i], {32'(i), 32'h100 + 32'(i)});
    // R7: 32-bit auto-increment
    wr(3'd0, (1 << 5) | (2 << 6) | CLR);
    wr(3'd1, 32'h20);
    wr(3'd3, 32'hAAAA_0001); wait_idle();
    wr(3'd3, 32'hBBBB_0002); wait_idle();
    rd(3'd1, v); check("R7 addr after 2x4", v, 64'h28);
    check("R7 autoinc 32 data", mem[4], 64'hBBBB_0002_AAAA_0001);
    // R12: error response, no step, then blocked
    wr(3'd0, (1 << 5) | (3 << 6) | CLR);
    wr(3'd1, 32'h200);
    wr(3'd3, 32'h0); wait_idle();
    rd(3'd0, v); check("R12 error code", v[4:2], 2);
    rd(3'd1, v); check("R7 no step after error", v, 64'h200);
    wr(3'd1, 32'h30);
    t0 = txn_cnt;
    wr(3'd3, 32'h1); repeat (4) @(negedge clk);
    check("R9 blocked by error code", 64'(txn_cnt - t0), 0);
    // R5: reads, 64-bit then 32-bit
    wr(3'd0, (3 << 6) | CLR);
    wr(3'd1, 32'h8); wr(3'd0, (3 << 6) | (1 << 9)); wait_idle();
    rd(3'd4, v); check("R5 64 read hi", v, 1);
    rd(3'd3, v); check("R5 64 read lo", v, 64'h101);
    wr(3'd1, 32'h24); wr(3'd0, (2 << 6) | (1 << 9)); wait_idle();
    rd(3'd3, v); check("R5 32 read lo", v, 64'hBBBB_0002);
    rd(3'd4, v); check("R5 32 read keeps hi", v, 1);
    // R6 / R8 / R9: busy collisions
    stall_n = 6;
    wr(3'd0, (3 << 6) | CLR);
    wr(3'd1, 32'h30); wr(3'd4, 32'h77); wr(3'd3, 32'hAA);
    rd(3'd0, v); check("R6 busy while pending", v[0], 1);
    wr(3'd3, 32'hBB);
    rd(3'd1, v);
    wait_idle();
    rd(3'd0, v); check("R8 busy-error set", v[1], 1);
    check("R8 dropped write", mem[6], 64'h77_0000_00AA);
    t0 = txn_cnt;
    wr(3'd3, 32'hCC); repeat (10) @(negedge clk);
    check("R9 blocked by busy-error", 64'(txn_cnt - t0), 0);
    check("R9 memory untouched", mem[6], 64'h77_0000_00AA);
    wr(3'd0, (3 << 6) | 2);
    rd(3'd0, v); check("R9 busy-error cleared", v[1], 0);
    wr(3'd3, 32'hDD); wait_idle();
    check("R9 access after clear", mem[6], 64'h77_0000_00DD);
    check("R6 request held while stalled", 64'(hold_viol), 0);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule